// File: doc/BRIEF.md
# RTC Sub-Second Tick and Interrupt Registers

This block is the register front end of a real-time clock. It counts a reference-clock enable in a 15-bit sub-second counter. When that counter wraps it emits a one-cycle seconds pulse, which the time-of-day counters outside the block use as their carry. It also gathers two interrupt sources into a status register that software clears by writing one. The first source is a per-field increment strobe filtered by a select register. The second is a per-field alarm match filtered by a mask register and sampled on the seconds pulse.

Software reaches five word registers over a simple single-cycle bus: interrupt status (0x00), tick counter (0x04), clock control (0x08), increment select (0x0C) and alarm mask (0x10). Reads are combinational from the address. Writes take effect at the clock edge on which `bus_wr` is high. The counter is run by a three-state control machine whose states are ST_HALT, ST_RUN and ST_HOLD. The named transitions are:
- *start* (ST_HALT to ST_RUN, enable set and hold clear)
- *stop* (ST_RUN to ST_HALT, enable cleared)
- *freeze* (ST_HALT or ST_RUN to ST_HOLD, hold set)
- *release* (ST_HOLD to ST_RUN or ST_HALT, hold cleared, with enable choosing which)

Top module: `rtc_tick_irq`

## Requirements
- R1: After reset every register reads zero, `irq` and `sec_pulse` are low, and the control machine is in ST_HALT.
- R2: In ST_RUN (control bit 0 = 1, bit 1 = 0) the tick counter advances by one on each clock edge where `ref_tick` is high. It does not advance when `ref_tick` is low or when control bit 0 is 0.
- R3: Reading offset 0x04 returns the tick counter in bits 15:1, with bit 0 and bits 31:16 as zero. Writes to 0x04 are ignored. Unmapped offsets read zero.
- R4: On the edge where the counter at 32767 takes a tick, it wraps to 0 and `sec_pulse` goes high for exactly the following cycle.
- R5: While control bit 1 is set, the counter is forced to zero by the second edge after the write and ignores ticks, whatever bit 0 holds. Control bits 3:2 have no effect on counting.
- R6: Control (4 bits at 0x08), increment select (8 bits at 0x0C) and alarm mask (8 bits at 0x10) read back as written, with upper bits zero.
- R7: Status bit 0 sets on the edge after a cycle in which `fld_inc[i]` and select bit i are both high. A strobe on an unselected field is ignored.
- R8: Status bit 1 sets on the edge ending a cycle with `sec_pulse` high, provided `fld_match[i]` is high for every field i whose mask bit is 0. When the mask is 0xFF, no alarm is raised.
- R9: Writing to 0x00 clears each status bit whose data bit is 1. Data bits of 0 leave the status unchanged.
- R10: When a set event and a write-one clear hit the same status bit in one cycle, the bit ends up set.
- R11: `irq` is high exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference-clock enable, one tick per high cycle |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fld_inc | input | 8 | Per-field increment strobes from the time counters |
| fld_match | input | 8 | Per-field alarm match flags from the comparators |
| sec_pulse | output | 1 | One-cycle pulse on sub-second wrap |
| irq | output | 1 | Interrupt request |

## Verification
A write to the control register moves the state machine at the write edge, so a counter change caused by it shows one edge later and a forced zero two edges later. Status bits appear one edge after the strobe, write or seconds pulse that causes them. The pulse itself is visible right after the wrapping edge, and `irq` and read data follow their registers with no delay. The bench changes inputs and samples at the falling edge, so each expected value is read after exactly the number of rising edges counted above. It sweeps every select bit against every strobe position and runs three full seconds to wrap the counter under different mask and match patterns.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } tick_state_e;

    localparam int OFS_STAT = 'h00;
    localparam int OFS_TICK = 'h04;
    localparam int OFS_CTRL = 'h08;
    localparam int OFS_ISEL = 'h0C;
    localparam int OFS_AMSK = 'h10;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_HOLD_BIT = 1;

    localparam int SRC_INC   = 0;
    localparam int SRC_ALARM = 1;
    localparam int NUM_SRC   = 2;

endpackage

// File: rtl/rtc_tick_fsm.sv
module rtc_tick_fsm
    import rtc_tick_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        hold,
    output tick_state_e state,
    output logic        run,
    output logic        clr
);

    tick_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HALT;
        end else begin
            state <= state_d;
        end
    end

    always_comb begin
        state_d = state;
        unique case (state)
            ST_HALT: begin
                if (hold)    state_d = ST_HOLD;   // freeze
                else if (en) state_d = ST_RUN;    // start
            end
            ST_RUN: begin
                if (hold)     state_d = ST_HOLD;  // freeze
                else if (!en) state_d = ST_HALT;  // stop
            end
            ST_HOLD: begin
                if (!hold) state_d = en ? ST_RUN : ST_HALT;  // release
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_comb begin
        run = 1'b0;
        clr = 1'b0;
        unique case (state)
            ST_HALT: ;
            ST_RUN:  run = 1'b1;
            ST_HOLD: clr = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_tick_cnt.sv
module rtc_tick_cnt #(
    parameter int TICK_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic              ref_tick,
    output logic [TICK_W-1:0] cnt,
    output logic              sec_pulse
);

    localparam logic [TICK_W-1:0] CNT_MAX = '1;

    logic adv;
    assign adv = run && ref_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            sec_pulse <= 1'b0;
        end else begin
            sec_pulse <= adv && (cnt == CNT_MAX);
            if (clr) begin
                cnt <= '0;
            end else if (adv) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_irq_stat.sv
module rtc_irq_stat #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] stat
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat[i] <= 1'b0;
            end else if (set[i]) begin
                stat[i] <= 1'b1;
            end else if (clr[i]) begin
                stat[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq
    import rtc_tick_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int TICK_W = 15,
    parameter int NFIELD = 8,
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NFIELD-1:0] fld_inc,
    input  logic [NFIELD-1:0] fld_match,
    output logic              sec_pulse,
    output logic              irq
);

    localparam logic [NFIELD-1:0] ALL_MASKED = '1;

    logic [CTRL_W-1:0]  ctrl_q, ctrl_d;
    logic [NFIELD-1:0]  isel_q;
    logic [NFIELD-1:0]  amsk_q;
    logic [TICK_W-1:0]  cnt_q;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] stat_set;
    logic [NUM_SRC-1:0] stat_clr;
    tick_state_e        state;
    logic               run;
    logic               clr;
    logic               wr_stat, wr_ctrl, wr_isel, wr_amsk;
    logic               unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:NFIELD];

    assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFS_STAT));
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_isel = bus_wr && (bus_addr == ADDR_W'(OFS_ISEL));
    assign wr_amsk = bus_wr && (bus_addr == ADDR_W'(OFS_AMSK));

    assign ctrl_d = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            isel_q <= '0;
            amsk_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (wr_isel) isel_q <= bus_wdata[NFIELD-1:0];
            if (wr_amsk) amsk_q <= bus_wdata[NFIELD-1:0];
        end
    end

    rtc_tick_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctrl_d[CTRL_EN_BIT]),
        .hold  (ctrl_d[CTRL_HOLD_BIT]),
        .state (state),
        .run   (run),
        .clr   (clr)
    );

    rtc_tick_cnt #(.TICK_W(TICK_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .clr       (clr),
        .ref_tick  (ref_tick),
        .cnt       (cnt_q),
        .sec_pulse (sec_pulse)
    );

    always_comb begin
        stat_set[SRC_INC]   = |(fld_inc & isel_q);
        stat_set[SRC_ALARM] = sec_pulse && (amsk_q != ALL_MASKED)
                              && (&(fld_match | amsk_q));
        stat_clr = wr_stat ? bus_wdata[NUM_SRC-1:0] : '0;
    end

    rtc_irq_stat #(.NSRC(NUM_SRC)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (stat_set),
        .clr   (stat_clr),
        .stat  (stat_q)
    );

    assign irq = |stat_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_STAT): bus_rdata[NUM_SRC-1:0] = stat_q;
            ADDR_W'(OFS_TICK): bus_rdata[TICK_W:1]    = cnt_q;
            ADDR_W'(OFS_CTRL): bus_rdata[CTRL_W-1:0]  = ctrl_q;
            ADDR_W'(OFS_ISEL): bus_rdata[NFIELD-1:0]  = isel_q;
            ADDR_W'(OFS_AMSK): bus_rdata[NFIELD-1:0]  = amsk_q;
            default:           bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_tick_irq_chk.sv
module rtc_tick_irq_chk
    import rtc_tick_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int TICK_W = 15,
    parameter int NFIELD = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ref_tick,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [NFIELD-1:0]   fld_inc,
    input logic [NFIELD-1:0]   fld_match,
    input logic                sec_pulse,
    input logic                irq,
    input tick_state_e         state,
    input logic [TICK_W-1:0]   cnt_q,
    input logic [NUM_SRC-1:0]  stat_q,
    input logic [NFIELD-1:0]   isel_q,
    input logic [NFIELD-1:0]   amsk_q
);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && ref_tick) |=> (cnt_q == TICK_W'($past(cnt_q) + 1'b1)));

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> !sec_pulse);

    p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (cnt_q == '0));

    p_inc_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((fld_inc & isel_q) != '0) |=> stat_q[SRC_INC]);

    p_alarm_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && amsk_q != '1 && ((fld_match | amsk_q) == '1)) |=> stat_q[SRC_ALARM]);

    p_w1c_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[SRC_INC]
         && ((fld_inc & isel_q) == '0)) |=> !stat_q[SRC_INC]);

    p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '0) |-> !irq);

endmodule

bind rtc_tick_irq rtc_tick_irq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TICK_W (TICK_W),
    .NFIELD (NFIELD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .fld_inc   (fld_inc),
    .fld_match (fld_match),
    .sec_pulse (sec_pulse),
    .irq       (irq),
    .state     (state),
    .cnt_q     (cnt_q),
    .stat_q    (stat_q),
    .isel_q    (isel_q),
    .amsk_q    (amsk_q)
);

// File: tb/rtc_tick_irq_test.sv
`timescale 1ns/1ps
module rtc_tick_irq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  fld_inc = '0;
    logic [7:0]  fld_match = '0;
    logic        sec_pulse;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    rtc_tick_irq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .fld_inc   (fld_inc),
        .fld_match (fld_match),
        .sec_pulse (sec_pulse),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (n) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 32; a += 4) begin
            rdreg(5'(a), rd);
            chk("R1 reset read", rd, 32'h0);
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 sec_pulse", {31'b0, sec_pulse}, 32'h0);

        // R2 no counting while disabled
        ticks(5);
        rdreg(5'h04, rd); chk("R2 disabled", rd, 32'h0);

        // R2/R3 counting when enabled
        wr(5'h08, 32'h1);
        ticks(5);
        rdreg(5'h04, rd); chk("R2 count 5", rd, 32'd10);
        wr(5'h04, 32'hFFFF_FFFF);
        rdreg(5'h04, rd); chk("R3 write ignored", rd, 32'd10);
        repeat (4) @(negedge clk);
        rdreg(5'h04, rd); chk("R2 idle no tick", rd, 32'd10);
        rdreg(5'h14, rd); chk("R3 unmapped", rd, 32'h0);

        // R5 hold
        wr(5'h08, 32'h3);
        @(negedge clk);
        rdreg(5'h04, rd); chk("R5 hold clears", rd, 32'h0);
        ticks(3);
        rdreg(5'h04, rd); chk("R5 hold ignores ticks", rd, 32'h0);
        wr(5'h08, 32'hD);
        rdreg(5'h08, rd); chk("R6 ctrl readback", rd, 32'hD);
        ticks(7);
        rdreg(5'h04, rd); chk("R5 bits 3:2 no effect", rd, 32'd14);

        // R6 readback of select and mask
        wr(5'h0C, 32'hFFFF_FFA5);
        rdreg(5'h0C, rd); chk("R6 isel readback", rd, 32'hA5);
        wr(5'h10, 32'h1234_565A);
        rdreg(5'h10, rd); chk("R6 amask readback", rd, 32'h5A);
        wr(5'h10, 32'h0);

        // R7/R9/R11 sweep select bit vs strobe position
        for (int i = 0; i < 8; i++) begin
            wr(5'h0C, 32'(1 << i));
            for (int j = 0; j < 8; j++) begin
                @(negedge clk); fld_inc = 8'(1 << j);
                @(negedge clk); fld_inc = '0;
                rdreg(5'h00, rd);
                chk("R7 inc select", rd, (i == j) ? 32'h1 : 32'h0);
                chk("R11 irq", {31'b0, irq}, (i == j) ? 32'h1 : 32'h0);
                wr(5'h00, 32'h1);
                rdreg(5'h00, rd); chk("R9 clear", rd, 32'h0);
            end
        end

        // R9 zero writes have no effect
        wr(5'h0C, 32'h01);
        @(negedge clk); fld_inc = 8'h01;
        @(negedge clk); fld_inc = '0;
        wr(5'h00, 32'h0);
        rdreg(5'h00, rd); chk("R9 zero no effect", rd, 32'h1);
        wr(5'h00, 32'h2);
        rdreg(5'h00, rd); chk("R9 other bit no effect", rd, 32'h1);
        wr(5'h00, 32'h1);

        // R10 set wins over clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'h00; bus_wdata = 32'h1; fld_inc = 8'h01;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; fld_inc = '0;
        rdreg(5'h00, rd); chk("R10 set wins", rd, 32'h1);
        wr(5'h00, 32'h1);
        wr(5'h0C, 32'h0);

        // restart counter from zero
        wr(5'h08, 32'h3);
        wr(5'h08, 32'h1);
        rdreg(5'h04, rd); chk("R5 released at zero", rd, 32'h0);

        // R4/R8 wrap 1: partial mask, all unmasked match
        wr(5'h10, 32'hF0);
        fld_match = 8'h0F;
        ticks(32767);
        rdreg(5'h04, rd); chk("R4 at max", rd, 32'hFFFE);
        chk("R4 no pulse yet", {31'b0, sec_pulse}, 32'h0);
        ticks(1);
        chk("R4 pulse", {31'b0, sec_pulse}, 32'h1);
        rdreg(5'h04, rd); chk("R4 wrapped", rd, 32'h0);
        @(negedge clk);
        chk("R4 pulse one cycle", {31'b0, sec_pulse}, 32'h0);
        rdreg(5'h00, rd); chk("R8 alarm set", rd, 32'h2);
        chk("R11 irq alarm", {31'b0, irq}, 32'h1);
        wr(5'h00, 32'h3);
        rdreg(5'h00, rd); chk("R9 alarm cleared", rd, 32'h0);

        // R8 wrap 2: everything masked
        wr(5'h10, 32'hFF);
        fld_match = 8'hFF;
        ticks(32768);
        @(negedge clk);
        rdreg(5'h00, rd); chk("R8 all masked", rd, 32'h0);

        // R8 wrap 3: unmasked field mismatches
        wr(5'h10, 32'h00);
        fld_match = 8'hFE;
        ticks(32768);
        @(negedge clk);
        rdreg(5'h00, rd); chk("R8 mismatch", rd, 32'h0);
        chk("R11 irq low", {31'b0, irq}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule